// File: doc/BRIEF.md
# Performance Event Qualifier

This block sits in front of one general-purpose performance counter and decides, every clock, by how much that counter should advance. The core presents the identifier of the event class it is reporting, the number of such events seen this cycle and the current privilege level. The block compares all of this with a 32-bit event-select control word and produces an increment value and a flag that says whether the counter advances at all. Counter storage, overflow detection and interrupt delivery belong to the counter bank that uses this block.

Two counting modes exist. With a zero threshold field the increment is the number of qualifying events in the cycle. With a nonzero threshold the block counts cycles instead. A cycle counts as one when its qualifying events reach the threshold. An invert bit turns that into "fewer than the threshold". An edge bit keeps only the first cycle of each run of true threshold results. The interrupt-on-overflow bit of the control word is passed straight to the counter bank.

Top module: `perf_event_qualifier`

## Requirements
- R1: When control bit 22 (enable) is 0, `inc_o` is 0 and `adv_o` is 0 in the following cycle, whatever the other inputs are.
- R2: When `priv_kernel_i` is 0 (user level), the cycle contributes only if control bit 16 is 1. Otherwise the result is treated as zero qualifying events and zero threshold hits.
- R3: When `priv_kernel_i` is 1 (kernel level), the cycle contributes only if control bit 17 is 1, with the same treatment as R2 otherwise.
- R4: Events qualify only when `evt_id_i` equals control bits 15:0. Here bits 7:0 are the event code and bits 15:8 are the unit mask. A mismatch means zero qualifying events.
- R5: With the threshold field (control bits 31:24) equal to 0, `inc_o` equals the qualifying event count one clock after the inputs are presented. Bits 23 and 18 then have no effect.
- R6: With a nonzero threshold, `inc_o` is 1 when the qualifying count is at least the threshold and 0 otherwise. A threshold above the largest count never hits, so over a stream the thresholded total is below the raw total.
- R7: With a nonzero threshold and control bit 23 (invert) set, the compare becomes "qualifying count less than threshold". A mismatching event id then counts as a hit.
- R8: With a nonzero threshold and control bit 18 (edge) set, `inc_o` is 1 only in cycles where the threshold result is true and the result of the previous cycle was false. A cycle that is disabled, filtered out by privilege, or in raw mode leaves a false previous result.
- R9: `ovf_irq_en_o` follows control bit 20 in the same cycle, with no register.
- R10: `adv_o` is 1 exactly when `inc_o` is nonzero.
- R11: After reset, `inc_o` is 0, `adv_o` is 0 and the previous-result reference is false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 32 | Event-select control word |
| evt_id_i | input | 16 | Unit mask (15:8) and event code (7:0) reported by the core |
| evt_cnt_i | input | CNT_W | Events of that class this cycle |
| priv_kernel_i | input | 1 | 1 = kernel level, 0 = user level |
| inc_o | output | CNT_W | Counter increment, registered |
| adv_o | output | 1 | Counter advances this cycle, registered |
| ovf_irq_en_o | output | 1 | Interrupt-on-overflow request bit for the counter bank |

## Verification
The bench builds the block with its default 4-bit event count, so every per-cycle count from 0 to 15 occurs. The random threshold values run past 15, which brings the never-hit and always-hit-when-inverted ends of the compare into reach alongside ordinary thresholds. Random control words mix enable, privilege and id mismatches with runs of identical words, so that edge mode sees long runs of true and false compare results. Directed sequences cover an edge run, the invert boundary and a raw-versus-threshold total.

// File: rtl/perfq_pkg.sv
package perfq_pkg;

    localparam int SEL_W      = 32;
    localparam int ID_W       = 16;
    localparam int TH_W       = 8;
    localparam int B_USER     = 16;
    localparam int B_KERN     = 17;
    localparam int B_EDGE     = 18;
    localparam int B_IRQ      = 20;
    localparam int B_ENABLE   = 22;
    localparam int B_INVERT   = 23;
    localparam int TH_LSB     = 24;

    typedef struct packed {
        logic [TH_W-1:0] thresh;
        logic            invert;
        logic            enable;
        logic            irq;
        logic            edge_det;
        logic            kern_en;
        logic            user_en;
        logic [ID_W-1:0] evt_sel;
    } sel_t;

    function automatic sel_t unpack_sel(input logic [SEL_W-1:0] w);
        sel_t s;
        s.thresh   = w[TH_LSB +: TH_W];
        s.invert   = w[B_INVERT];
        s.enable   = w[B_ENABLE];
        s.irq      = w[B_IRQ];
        s.edge_det = w[B_EDGE];
        s.kern_en  = w[B_KERN];
        s.user_en  = w[B_USER];
        s.evt_sel  = w[ID_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/perfq_filter.sv
module perfq_filter
    import perfq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  sel_t             sel_i,
    input  logic [ID_W-1:0]  evt_id_i,
    input  logic [CNT_W-1:0] evt_cnt_i,
    input  logic             priv_kernel_i,
    output logic             active_o,
    output logic [CNT_W-1:0] qual_cnt_o
);

    logic priv_ok;
    logic id_hit;

    always_comb begin
        priv_ok    = priv_kernel_i ? sel_i.kern_en : sel_i.user_en;
        active_o   = sel_i.enable && priv_ok;
        id_hit     = (evt_id_i == sel_i.evt_sel);
        qual_cnt_o = (active_o && id_hit) ? evt_cnt_i : '0;
    end

endmodule

// File: rtl/perfq_thresh.sv
module perfq_thresh
    import perfq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sel_t             sel_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] qual_cnt_i,
    output logic [CNT_W-1:0] inc_o
);

    localparam int CMP_W = (CNT_W > TH_W) ? CNT_W : TH_W;

    typedef struct packed {
        logic prev_hit;
    } st_t;

    st_t st_d, st_q;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] th_ext;
    logic             th_mode;
    logic             reach;
    logic             hit;

    always_comb begin
        st_d    = st_q;
        cnt_ext = CMP_W'(qual_cnt_i);
        th_ext  = CMP_W'(sel_i.thresh);
        th_mode = (sel_i.thresh != '0);
        reach   = (cnt_ext >= th_ext);
        hit     = active_i && th_mode && (reach ^ sel_i.invert);
        if (!active_i) begin
            inc_o = '0;
        end else if (!th_mode) begin
            inc_o = qual_cnt_i;
        end else if (sel_i.edge_det) begin
            inc_o = CNT_W'(hit && !st_q.prev_hit);
        end else begin
            inc_o = CNT_W'(hit);
        end
        st_d.prev_hit = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/perf_event_qualifier.sv
module perf_event_qualifier
    import perfq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      ctrl_i,
    input  logic [15:0]      evt_id_i,
    input  logic [CNT_W-1:0] evt_cnt_i,
    input  logic             priv_kernel_i,
    output logic [CNT_W-1:0] inc_o,
    output logic             adv_o,
    output logic             ovf_irq_en_o
);

    typedef struct packed {
        logic [CNT_W-1:0] inc;
        logic             adv;
    } out_t;

    sel_t             sel;
    logic             active;
    logic [CNT_W-1:0] qual_cnt;
    logic [CNT_W-1:0] inc_next;
    out_t             out_d, out_q;

    assign sel = unpack_sel(ctrl_i);

    perfq_filter #(.CNT_W(CNT_W)) u_filter (
        .sel_i         (sel),
        .evt_id_i      (evt_id_i),
        .evt_cnt_i     (evt_cnt_i),
        .priv_kernel_i (priv_kernel_i),
        .active_o      (active),
        .qual_cnt_o    (qual_cnt)
    );

    perfq_thresh #(.CNT_W(CNT_W)) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .active_i   (active),
        .qual_cnt_i (qual_cnt),
        .inc_o      (inc_next)
    );

    always_comb begin
        out_d     = out_q;
        out_d.inc = inc_next;
        out_d.adv = (inc_next != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign inc_o        = out_q.inc;
    assign adv_o        = out_q.adv;
    assign ovf_irq_en_o = sel.irq;

endmodule

// File: rtl/perfq_qualifier_chk.sv
module perfq_qualifier_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      ctrl_i,
    input logic [15:0]      evt_id_i,
    input logic [CNT_W-1:0] evt_cnt_i,
    input logic             priv_kernel_i,
    input logic [CNT_W-1:0] inc_o,
    input logic             adv_o
);

    logic [1:0]  age_q;
    logic [31:0] c1_q, c2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
            c1_q  <= '0;
            c2_q  <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            c1_q <= ctrl_i;
            c2_q <= c1_q;
        end
    end

    p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0 && !c1_q[22]) |-> (inc_o == '0));

    p_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0 && ctrl_i[22] && ctrl_i[31:24] == 8'd0 && evt_id_i == ctrl_i[15:0]
         && (priv_kernel_i ? ctrl_i[17] : ctrl_i[16]))
        |=> (inc_o == $past(evt_cnt_i)));

    p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0 && c1_q[31:24] != 8'd0) |-> (inc_o <= CNT_W'(1)));

    p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2 && c2_q[31:24] != 8'd0 && c1_q[31:24] != 8'd0 && c1_q[18]
         && $past(inc_o) != '0) |-> (inc_o == '0));

    p_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o == (inc_o != '0));

endmodule

bind perf_event_qualifier perfq_qualifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_i        (ctrl_i),
    .evt_id_i      (evt_id_i),
    .evt_cnt_i     (evt_cnt_i),
    .priv_kernel_i (priv_kernel_i),
    .inc_o         (inc_o),
    .adv_o         (adv_o)
);

// File: tb/test_perf_event_qualifier.sv
module test_perf_event_qualifier;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      ctrl_i = '0;
    logic [15:0]      evt_id_i = '0;
    logic [CNT_W-1:0] evt_cnt_i = '0;
    logic             priv_kernel_i = 1'b0;
    logic [CNT_W-1:0] inc_o;
    logic             adv_o;
    logic             ovf_irq_en_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  m_prev = 1'b0;
    int  raw_sum = 0;
    int  th_sum  = 0;

    always #4 clk = ~clk;

    perf_event_qualifier #(.CNT_W(CNT_W)) i_perf_event_qualifier (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_i        (ctrl_i),
        .evt_id_i      (evt_id_i),
        .evt_cnt_i     (evt_cnt_i),
        .priv_kernel_i (priv_kernel_i),
        .inc_o         (inc_o),
        .adv_o         (adv_o),
        .ovf_irq_en_o  (ovf_irq_en_o)
    );

    function automatic logic [31:0] mk(input logic [7:0] th, input bit inv, input bit en,
                                       input bit irq, input bit edg, input bit kern,
                                       input bit usr, input logic [15:0] id);
        mk = {th, inv, en, 1'b0, irq, 1'b0, edg, kern, usr, id};
    endfunction

    function automatic string tag_of(input logic [31:0] c, input bit kern);
        if (!c[22]) return "R1";
        if (kern && !c[17]) return "R3";
        if (!kern && !c[16]) return "R2";
        if (c[31:24] == 0) return "R5";
        if (c[18]) return "R8";
        if (c[23]) return "R7";
        return "R6";
    endfunction

    function automatic int ref_step(input logic [31:0] c, input logic [15:0] id,
                                    input int cnt, input bit kern);
        bit act, res, hit;
        int q, r;
        act = c[22] && (kern ? c[17] : c[16]);
        q   = (act && id == c[15:0]) ? cnt : 0;
        hit = 1'b0;
        if (!act) r = 0;
        else if (c[31:24] == 0) r = q;
        else begin
            res = (q >= int'(c[31:24])) ^ c[23];
            hit = res;
            r   = c[18] ? int'(res && !m_prev) : int'(res);
        end
        m_prev = hit;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] c, input logic [15:0] id, input int cnt,
                        input bit kern, input string tag);
        int exp;
        @(negedge clk);
        ctrl_i = c; evt_id_i = id; evt_cnt_i = CNT_W'(cnt); priv_kernel_i = kern;
        exp = ref_step(c, id, cnt, kern);
        #1;
        check("R9", int'(ovf_irq_en_o), int'(c[20]));
        @(posedge clk);
        #1;
        check(tag, int'(inc_o), exp);
        check("R10", int'(adv_o), int'(exp != 0));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #20;
        check("R11", int'(inc_o), 0);
        check("R11", int'(adv_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: disabled word ignores a matching stream
        step(mk(8'd0, 0, 0, 0, 0, 1, 1, 16'h00c0), 16'h00c0, 9, 0, "R1");
        // R2 / R3: privilege filter
        step(mk(8'd0, 0, 1, 0, 0, 1, 0, 16'h00c0), 16'h00c0, 7, 0, "R2");
        step(mk(8'd0, 0, 1, 0, 0, 1, 0, 16'h00c0), 16'h00c0, 7, 1, "R3");
        step(mk(8'd0, 0, 1, 0, 0, 0, 1, 16'h00c0), 16'h00c0, 7, 1, "R3");
        step(mk(8'd0, 0, 1, 0, 0, 0, 1, 16'h00c0), 16'h00c0, 7, 0, "R2");
        // R4: unit mask differs
        step(mk(8'd0, 0, 1, 1, 0, 1, 1, 16'h412e), 16'h4f2e, 5, 0, "R4");
        // R5: raw count, invert and edge have no effect
        step(mk(8'd0, 1, 1, 0, 1, 1, 1, 16'h003c), 16'h003c, 15, 1, "R5");
        step(mk(8'd0, 1, 1, 0, 1, 1, 1, 16'h003c), 16'h003c, 15, 1, "R5");
        // R7: invert boundary
        step(mk(8'd3, 1, 1, 0, 0, 1, 1, 16'h00c4), 16'h00c4, 2, 0, "R7");
        step(mk(8'd3, 1, 1, 0, 0, 1, 1, 16'h00c4), 16'h00c4, 3, 0, "R7");
        step(mk(8'd3, 1, 1, 0, 0, 1, 1, 16'h00c4), 16'h0000, 9, 0, "R7");
        // R8: edge run 1,1,0,1 with threshold 1
        step(mk(8'd1, 0, 1, 0, 1, 1, 1, 16'h00c5), 16'h00c5, 1, 0, "R8");
        step(mk(8'd1, 0, 1, 0, 1, 1, 1, 16'h00c5), 16'h00c5, 4, 0, "R8");
        step(mk(8'd1, 0, 1, 0, 1, 1, 1, 16'h00c5), 16'h00c5, 0, 0, "R8");
        step(mk(8'd1, 0, 1, 0, 1, 1, 1, 16'h00c5), 16'h00c5, 2, 0, "R8");
        // R6: threshold above max never hits
        step(mk(8'd16, 0, 1, 0, 0, 1, 1, 16'h00c0), 16'h00c0, 15, 0, "R6");
        // R6: thresholded total below raw total
        for (int i = 0; i < 12; i++) begin
            int c;
            c = i % 4;
            step(mk(8'd0, 0, 1, 0, 0, 1, 1, 16'h00c0), 16'h00c0, c, 0, "R5");
            raw_sum += int'(inc_o);
            step(mk(8'd2, 0, 1, 0, 0, 1, 1, 16'h00c0), 16'h00c0, c, 0, "R6");
            th_sum += int'(inc_o);
        end
        check("R6", int'(th_sum < raw_sum), 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] c;
            logic [15:0] id;
            bit kern;
            c = $urandom();
            if ($urandom_range(0, 7) != 0) c[22] = 1'b1;
            case ($urandom_range(0, 3))
                0: c[31:24] = 8'd0;
                1: c[31:24] = 8'($urandom_range(1, 4));
                2: c[31:24] = 8'($urandom_range(1, 20));
                default: c[31:24] = 8'd0;
            endcase
            id   = ($urandom_range(0, 5) != 0) ? c[15:0] : 16'($urandom());
            kern = 1'($urandom());
            for (int k = 0; k < int'($urandom_range(1, 4)); k++) begin
                int cnt;
                cnt = $urandom_range(0, 15);
                step(c, id, cnt, kern, tag_of(c, kern));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule